// File: doc/BRIEF.md
# Change-of-Flow Trace Filter

The filter watches a stream of retired-instruction events and decides which program-counter addresses become trace records when tracing runs in normal (change-of-flow) mode. Each clock it may see one completed instruction, described by a class code, a taken flag, an indexed-addressing flag and its 18-bit source and destination addresses. In the same clock it may see an interrupt-vector event with its vector address and a flag marking a background-debug vector. It emits at most one record per clock: a valid strobe, an 18-bit address and a flag that tells whether the address is a source or a destination. The records feed a trace buffer.

Only control transfers that cannot be predicted statically are recorded. Taken conditional branches give their source address. Indexed jumps, subroutine calls and far calls give their destination. Returns give their destination, and non-debug interrupt vectors give the vector address. A small state machine arbitrates when an instruction record and a vector event arrive together. It has two states. IDLE means no record is waiting. HOLD means one record waits in the hold slot. The transitions are: IDLE to HOLD (`t_defer`) when an instruction record and a vector coincide; HOLD to HOLD (`t_refill`) when a new candidate arrives while the held record is released; HOLD to IDLE (`t_drain`) when the held record is released with nothing new; and any state to IDLE (`t_flush`) while tracing is disabled.

Top module: `cof_trace_filter`

## Requirements
- R1: After reset `rec_valid` is 0 and the state is IDLE.
- R2: Class codes 1, 2, 3 and 4 (short, long, bit-conditional branch and loop primitive) produce a record with `rec_addr` = `ret_src` and `rec_is_dst` = 0 when `ret_taken` is 1. They produce no record when `ret_taken` is 0.
- R3: Class codes 5, 6 and 7 (jump, subroutine call, far call) produce a record with `rec_addr` = `ret_dst` and `rec_is_dst` = 1 when `ret_indexed` is 1. They produce no record when `ret_indexed` is 0.
- R4: Class codes 8, 9 and 10 (return from interrupt, return from subroutine, return from far call) always produce a record with `rec_addr` = `ret_dst` and `rec_is_dst` = 1.
- R5: Class codes 0 and 11 to 15 (unconditional short and long branch, branch to subroutine, enter background, other instructions) never produce a record.
- R6: A vector event with `vec_bdm` = 0 produces a record with `rec_addr` = `vec_addr` and `rec_is_dst` = 1. A vector event with `vec_bdm` = 1 produces none.
- R7: A record appears on the outputs in the clock after the inputs that caused it, and `rec_valid` is high for exactly one clock per record.
- R8: When an instruction record and a recordable vector arrive in the same clock, the instruction record is emitted first and the vector record is emitted in the following clock (`t_defer`, then `t_drain`).
- R9: While in HOLD, the held record is released. A single new candidate arriving in that clock is held and released in the next clock (`t_refill`). If both an instruction record and a vector arrive in that clock, the instruction record is held and the vector is discarded.
- R10: While `trace_en` is 0, no record is emitted in the following clock, and any held record is discarded (`t_flush`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Enables record generation |
| ret_valid | input | 1 | A retired instruction is presented |
| ret_class | input | 4 | Instruction class code |
| ret_taken | input | 1 | Conditional branch was taken |
| ret_indexed | input | 1 | Jump/call used indexed addressing |
| ret_src | input | 18 | Address of the retired instruction |
| ret_dst | input | 18 | Address control passed to |
| vec_valid | input | 1 | An interrupt vector is taken |
| vec_bdm | input | 1 | The vector is a background-debug vector |
| vec_addr | input | 18 | Vector address |
| rec_valid | output | 1 | Record strobe |
| rec_addr | output | 18 | Recorded address |
| rec_is_dst | output | 1 | 1 = destination or vector, 0 = source |

## Verification
The hard situation to reach is the HOLD state receiving fresh work. A second candidate, or even a coinciding pair, must arrive in exactly the clock in which the held vector is released. The bench first drives a coinciding instruction and vector, then in the very next clock drives a second event. It does this for each of single instruction, single vector and pair, and it also drops `trace_en` in that clock. This checks the refill, discard and flush paths against a per-clock model of the hold slot. The classification itself is swept over every class code with every combination of taken, indexed and vector flags.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
    localparam int ADDR_W = 18;
    localparam int CLS_W  = 4;

    // Instruction class codes
    localparam logic [CLS_W-1:0] CLS_BR_SHORT = 4'd1;
    localparam logic [CLS_W-1:0] CLS_BR_LONG  = 4'd2;
    localparam logic [CLS_W-1:0] CLS_BR_BIT   = 4'd3;
    localparam logic [CLS_W-1:0] CLS_LOOP     = 4'd4;
    localparam logic [CLS_W-1:0] CLS_JMP      = 4'd5;
    localparam logic [CLS_W-1:0] CLS_JSR      = 4'd6;
    localparam logic [CLS_W-1:0] CLS_CALL     = 4'd7;
    localparam logic [CLS_W-1:0] CLS_RTI      = 4'd8;
    localparam logic [CLS_W-1:0] CLS_RTS      = 4'd9;
    localparam logic [CLS_W-1:0] CLS_RTC      = 4'd10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic              vld;
        logic              is_dst;
        logic [ADDR_W-1:0] addr;
    } trace_rec_t;
endpackage

// File: rtl/cof_classify.sv
module cof_classify
    import cof_trace_pkg::*;
(
    input  logic              ret_valid,
    input  logic [CLS_W-1:0]  ret_class,
    input  logic              ret_taken,
    input  logic              ret_indexed,
    input  logic [ADDR_W-1:0] ret_src,
    input  logic [ADDR_W-1:0] ret_dst,
    output trace_rec_t        cof_rec
);
    always_comb begin
        cof_rec = '0;
        if (ret_valid) begin
            unique case (ret_class)
                CLS_BR_SHORT, CLS_BR_LONG, CLS_BR_BIT, CLS_LOOP: begin
                    cof_rec.vld    = ret_taken;
                    cof_rec.is_dst = 1'b0;
                    cof_rec.addr   = ret_src;
                end
                CLS_JMP, CLS_JSR, CLS_CALL: begin
                    cof_rec.vld    = ret_indexed;
                    cof_rec.is_dst = 1'b1;
                    cof_rec.addr   = ret_dst;
                end
                CLS_RTI, CLS_RTS, CLS_RTC: begin
                    cof_rec.vld    = 1'b1;
                    cof_rec.is_dst = 1'b1;
                    cof_rec.addr   = ret_dst;
                end
                default: cof_rec = '0;
            endcase
        end
    end
endmodule

// File: rtl/cof_vector_gate.sv
module cof_vector_gate
    import cof_trace_pkg::*;
(
    input  logic              vec_valid,
    input  logic              vec_bdm,
    input  logic [ADDR_W-1:0] vec_addr,
    output trace_rec_t        vec_rec
);
    always_comb begin
        vec_rec.vld    = vec_valid && !vec_bdm;
        vec_rec.is_dst = 1'b1;
        vec_rec.addr   = vec_addr;
    end
endmodule

// File: rtl/cof_trace_filter.sv
module cof_trace_filter
    import cof_trace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              ret_valid,
    input  logic [3:0]        ret_class,
    input  logic              ret_taken,
    input  logic              ret_indexed,
    input  logic [17:0]       ret_src,
    input  logic [17:0]       ret_dst,
    input  logic              vec_valid,
    input  logic              vec_bdm,
    input  logic [17:0]       vec_addr,
    output logic              rec_valid,
    output logic [17:0]       rec_addr,
    output logic              rec_is_dst
);
    trace_rec_t cof_rec, vec_rec;
    trace_rec_t hold_q, hold_d;
    trace_rec_t out_q, out_d;
    arb_state_e state_q, state_d;

    cof_classify u_classify (
        .ret_valid   (ret_valid),
        .ret_class   (ret_class),
        .ret_taken   (ret_taken),
        .ret_indexed (ret_indexed),
        .ret_src     (ret_src),
        .ret_dst     (ret_dst),
        .cof_rec     (cof_rec)
    );

    cof_vector_gate u_vgate (
        .vec_valid (vec_valid),
        .vec_bdm   (vec_bdm),
        .vec_addr  (vec_addr),
        .vec_rec   (vec_rec)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            out_q   <= out_d;
        end
    end

    // Next state and output selection
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        out_d   = '0;
        if (!trace_en) begin
            state_d = ST_IDLE;           // t_flush
            hold_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cof_rec.vld && vec_rec.vld) begin
                        out_d   = cof_rec;
                        hold_d  = vec_rec;
                        state_d = ST_HOLD; // t_defer
                    end else if (cof_rec.vld) begin
                        out_d = cof_rec;
                    end else if (vec_rec.vld) begin
                        out_d = vec_rec;
                    end
                end
                ST_HOLD: begin
                    out_d = hold_q;
                    if (cof_rec.vld) begin
                        hold_d  = cof_rec; // t_refill, vector dropped if both
                        state_d = ST_HOLD;
                    end else if (vec_rec.vld) begin
                        hold_d  = vec_rec; // t_refill
                        state_d = ST_HOLD;
                    end else begin
                        hold_d  = '0;
                        state_d = ST_IDLE; // t_drain
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign rec_valid  = out_q.vld;
    assign rec_addr   = out_q.addr;
    assign rec_is_dst = out_q.is_dst;

    // R10
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(trace_en));

    // R9
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && trace_en) |=> rec_valid);

    // R2
    src_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_is_dst) |-> ($past(ret_valid && ret_taken) || $past(state_q == ST_HOLD)));

    // R6
    bdm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !ret_valid && vec_valid && vec_bdm) |=> !rec_valid);

    // R8
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && trace_en && cof_rec.vld && vec_rec.vld) |=> (state_q == ST_HOLD));

    // R1
    reset_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rec_valid && state_q == ST_IDLE));
endmodule

// File: tb/cof_trace_filter_tb_top.sv
module cof_trace_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        ret_valid = 1'b0;
    logic [3:0]  ret_class = '0;
    logic        ret_taken = 1'b0;
    logic        ret_indexed = 1'b0;
    logic [17:0] ret_src = '0;
    logic [17:0] ret_dst = '0;
    logic        vec_valid = 1'b0;
    logic        vec_bdm = 1'b0;
    logic [17:0] vec_addr = '0;
    logic        rec_valid;
    logic [17:0] rec_addr;
    logic        rec_is_dst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected-model hold slot
    bit          m_hold;
    bit          m_hdst;
    logic [17:0] m_haddr;

    always #4 clk = ~clk;

    cof_trace_filter dut_i (.*);

    task automatic chk(input string req, input bit ev, input bit ed, input logic [17:0] ea);
        checks++;
        if (rec_valid !== ev || (ev && (rec_addr !== ea || rec_is_dst !== ed))) begin
            fails++;
            $display("FAIL %s: got v=%0b a=%h d=%0b expected v=%0b a=%h d=%0b",
                     req, rec_valid, rec_addr, rec_is_dst, ev, ea, ed);
        end
    endtask

    // Classification computed from the requirement text
    function automatic void classify(input int c, input bit tk, input bit ix,
                                     output bit hit, output bit dst, output string req);
        hit = 0; dst = 0; req = "R5";
        if (c >= 1 && c <= 4)      begin hit = tk; dst = 0; req = "R2"; end
        else if (c >= 5 && c <= 7) begin hit = ix; dst = 1; req = "R3"; end
        else if (c >= 8 && c <= 10) begin hit = 1; dst = 1; req = "R4"; end
    endfunction

    task automatic drive(input bit en, input bit rv, input int c, input bit tk, input bit ix,
                         input logic [17:0] s, input logic [17:0] d,
                         input bit vv, input bit vb, input logic [17:0] va);
        trace_en = en; ret_valid = rv; ret_class = 4'(c); ret_taken = tk;
        ret_indexed = ix; ret_src = s; ret_dst = d;
        vec_valid = vv; vec_bdm = vb; vec_addr = va;
    endtask

    task automatic idle_in();
        drive(1, 0, 0, 0, 0, '0, '0, 0, 0, '0);
    endtask

    initial begin
        m_hold = 0; m_hdst = 0; m_haddr = '0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1", 0, 0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 0, 0, '0);

        // Sweep: class x taken x indexed x vector(none, normal, bdm)
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 12; f++) begin
                bit tk, ix, vv, vb, hit, dst;
                string req;
                logic [17:0] s, d, va;
                tk = f[0]; ix = f[1];
                vv = (f >= 4); vb = (f >= 8);
                s  = 18'(c * 4099 + f * 7 + 1);
                d  = 18'(c * 911 + f * 131 + 18'h20000);
                va = 18'(18'h3FF00 + c + f);
                classify(c, tk, ix, hit, dst, req);
                drive(1, 1, c, tk, ix, s, d, vv, vb, va);
                @(negedge clk);
                idle_in();
                if (hit) chk({req, "/R7"}, 1, dst, dst ? d : s);
                else if (vv && !vb) chk("R6", 1, 1, va);
                else chk(vv ? "R6" : req, 0, 0, '0);
                @(negedge clk);
                if (hit && vv && !vb) chk("R8", 1, 1, va);
                else chk("R7", 0, 0, '0);
            end
        end

        // Vector alone, normal and bdm
        drive(1, 0, 0, 0, 0, '0, '0, 1, 0, 18'h1ABCD);
        @(negedge clk); idle_in();
        chk("R6", 1, 1, 18'h1ABCD);
        drive(1, 0, 0, 0, 0, '0, '0, 1, 1, 18'h1ABCE);
        @(negedge clk); idle_in();
        chk("R6", 0, 0, '0);

        // HOLD refill cases: k=0 cof alone, 1 vector alone, 2 both, 3 enable low
        for (int k = 0; k < 4; k++) begin
            drive(1, 1, 9, 0, 0, 18'h00100, 18'h0AA00 + 18'(k), 1, 0, 18'h3FE00 + 18'(k));
            @(negedge clk);
            chk("R8", 1, 1, 18'h0AA00 + 18'(k));
            case (k)
                0: drive(1, 1, 2, 1, 0, 18'h05550, 18'h0, 0, 0, 18'h0);
                1: drive(1, 0, 0, 0, 0, 18'h0, 18'h0, 1, 0, 18'h3F111);
                2: drive(1, 1, 6, 0, 1, 18'h0, 18'h06660, 1, 0, 18'h3F222);
                default: drive(0, 1, 8, 0, 0, 18'h0, 18'h07770, 0, 0, 18'h0);
            endcase
            @(negedge clk);
            idle_in();
            if (k == 3) chk("R10", 0, 0, '0);
            else chk("R8", 1, 1, 18'h3FE00 + 18'(k));
            @(negedge clk);
            case (k)
                0: chk("R9", 1, 0, 18'h05550);
                1: chk("R9", 1, 1, 18'h3F111);
                2: chk("R9", 1, 1, 18'h06660);
                default: chk("R10", 0, 0, '0);
            endcase
            @(negedge clk);
            chk("R9", 0, 0, '0);
        end

        // Enable low sweep of recordable events
        for (int c = 1; c <= 10; c++) begin
            drive(0, 1, c, 1, 1, 18'h11111, 18'h22222, 1, 0, 18'h33333);
            @(negedge clk); idle_in();
            chk("R10", 0, 0, '0);
            @(negedge clk);
            chk("R10", 0, 0, '0);
        end

        // Reset mid-hold clears state
        drive(1, 1, 8, 0, 0, '0, 18'h00042, 1, 0, 18'h00043);
        @(negedge clk);
        rst_n = 1'b0; idle_in();
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", 0, 0, '0);
        @(negedge clk);
        chk("R1", 0, 0, '0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got running expected finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule